// File: doc/BRIEF.md
# Six-Output Commutated PWM Generator

This block drives the six gate signals of a three-phase bridge: one high-side and one low-side switch per phase. A free-running counter sets the carrier period, and a compare against a duty value gives the modulating waveform. A controller writes the period and the duty value at any time, usually values it has worked out from a sampled speed-setting voltage. The counter picks both values up only at the end of a carrier cycle, so a cycle is never cut short or stretched partway through.

A three-bit commutation step selects which two phases conduct. One phase has its high side switched by the PWM waveform. A second phase has its low side held on. Both switches of the third phase stay off, so that winding floats and its back-EMF can be sensed. Each phase has a dead-time guard. When a phase hands over from one of its switches to the other, both switches stay off for a programmed number of clocks. The guard does not act when the same switch is pulsed again by the PWM.

Top module: `commutated_pwm6`

## Requirements
- R1: While `rst_n` is low, all six gate outputs are low.
- R2: The carrier counts from 0 to P-1, where P is the latched period (a value of 0 acts as 1). With 0 < D < P, the PWM-switched high side is on for the first D counts of every P-clock cycle.
- R3: A latched duty D >= P keeps the switched high side on for the whole cycle. D = 0 keeps it off.
- R4: `period_cfg` and `duty_cfg` are copied into working registers only on the clock at which the counter wraps, or on any clock while `run_en` is low. Writes at other times first take effect in the next carrier cycle.
- R5: Step encoding as (PWM high-side phase, low-side-on phase), with phases 0, 1, 2: 0 → (0,1), 1 → (0,2), 2 → (1,2), 3 → (1,0), 4 → (2,0), 5 → (2,1).
- R6: For a valid step with `run_en` high, exactly one phase is undriven, and both of its gates are low.
- R7: Step 6 or 7, or `run_en` low, drives all six gates low from the next clock. While `run_en` is low, the counter is held at 0.
- R8: The high and low gates of one phase are never on together. After one side turns off, the opposite side of that phase stays off for at least `dead_cfg`+1 clocks. Re-pulsing the same side is not delayed.
- R9: The gate outputs are registered: they follow the counter, duty and step values seen at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| run_en | input | 1 | Enables the bridge. Low holds the counter and forces all gates off |
| period_cfg | input | 16 | Carrier period in clocks |
| duty_cfg | input | 16 | High-side on-time in clocks per carrier cycle |
| dead_cfg | input | 8 | Dead time in clocks between the two switches of a phase |
| comm_step | input | 3 | Commutation step, 0 to 5 valid |
| gate_hi | output | 3 | High-side gate per phase (bit = phase) |
| gate_lo | output | 3 | Low-side gate per phase (bit = phase) |

## Verification
The assertions assume that `dead_cfg` changes only while no phase is handing over from one switch to the other. A change at the moment one side turns off could shorten that gap. The stimulus changes `dead_cfg` only while the step and duty are steady and no handover is pending. `period_cfg`, `duty_cfg` and `comm_step` change freely, including partway through a carrier cycle, to exercise shadow loading and abrupt step jumps. Steps 6 and 7 are driven on purpose, as required inputs.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int NUM_PHASES = 3;
  localparam int STEP_W     = 3;
  localparam int NUM_STEPS  = 6;

  typedef enum logic [1:0] {
    PM_OFF      = 2'd0,
    PM_HIGH_PWM = 2'd1,
    PM_LOW_ON   = 2'd2
  } phase_mode_e;
endpackage

// File: rtl/cpwm_carrier.sv
module cpwm_carrier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o,
  output logic             wrap_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, duty_q;
  logic             load;

  // next state
  always_comb begin
    wrap_o = (EXT_W'(cnt_q) + EXT_W'(1)) >= EXT_W'(per_q);
    load   = !run || wrap_o;
    cnt_d  = load ? '0 : cnt_q + 1'b1;
    pwm_o  = cnt_q < duty_q;
  end

  // counter register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // shadow registers with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      duty_q <= '0;
    end else if (load) begin
      per_q  <= period_i;
      duty_q <= duty_i;
    end
  end

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && per_q != '0) |-> (cnt_q < per_q)); // R2

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_o) |=> ($stable(per_q) && $stable(duty_q))); // R4

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/cpwm_step_decode.sv
module cpwm_step_decode
  import cpwm_pkg::*;
(
  input  logic              run,
  input  logic [STEP_W-1:0] step_i,
  output phase_mode_e       mode_o [NUM_PHASES]
);
  logic [NUM_PHASES-1:0] hi_sel;
  logic [NUM_PHASES-1:0] lo_sel;

  always_comb begin
    hi_sel = '0;
    lo_sel = '0;
    case (step_i)
      3'd0: begin hi_sel = 3'b001; lo_sel = 3'b010; end
      3'd1: begin hi_sel = 3'b001; lo_sel = 3'b100; end
      3'd2: begin hi_sel = 3'b010; lo_sel = 3'b100; end
      3'd3: begin hi_sel = 3'b010; lo_sel = 3'b001; end
      3'd4: begin hi_sel = 3'b100; lo_sel = 3'b001; end
      3'd5: begin hi_sel = 3'b100; lo_sel = 3'b010; end
      default: begin hi_sel = '0; lo_sel = '0; end
    endcase
    if (!run) begin
      hi_sel = '0;
      lo_sel = '0;
    end
  end

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_mode
    always_comb begin
      if (lo_sel[p])      mode_o[p] = PM_LOW_ON;
      else if (hi_sel[p]) mode_o[p] = PM_HIGH_PWM;
      else                mode_o[p] = PM_OFF;
    end
  end
endmodule

// File: rtl/cpwm_dead_band.sv
module cpwm_dead_band #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DT_W-1:0] dead_i,
  input  logic            hi_req_i,
  input  logic            lo_req_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic            hi_q, hi_d;
  logic            lo_q, lo_d;
  logic            last_hi_q, last_hi_d;
  logic [DT_W-1:0] gap_q, gap_d;
  logic            gap_ok;

  // next state
  always_comb begin
    gap_ok = gap_q >= dead_i;
    hi_d   = hi_req_i && !lo_q && (last_hi_q || gap_ok);
    lo_d   = lo_req_i && !hi_req_i && !hi_q && (!last_hi_q || gap_ok);
    if (hi_q || lo_q)       gap_d = '0;
    else if (gap_q != '1)   gap_d = gap_q + 1'b1;
    else                    gap_d = gap_q;
    if (hi_q)               last_hi_d = 1'b1;
    else if (lo_q)          last_hi_d = 1'b0;
    else                    last_hi_d = last_hi_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= 1'b0;
      lo_q      <= 1'b0;
      last_hi_q <= 1'b0;
      gap_q     <= '1;
    end else begin
      hi_q      <= hi_d;
      lo_q      <= lo_d;
      last_hi_q <= last_hi_d;
      gap_q     <= gap_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  AST_LO_FALL_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lo_q) |-> !hi_q); // R8

  AST_HI_FALL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((dead_i != '0) && $fell(hi_q)) |=> !lo_q); // R8
endmodule

// File: rtl/commutated_pwm6.sv
module commutated_pwm6
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_en,
  input  logic [CNT_W-1:0]      period_cfg,
  input  logic [CNT_W-1:0]      duty_cfg,
  input  logic [DT_W-1:0]       dead_cfg,
  input  logic [STEP_W-1:0]     comm_step,
  output logic [NUM_PHASES-1:0] gate_hi,
  output logic [NUM_PHASES-1:0] gate_lo
);
  logic                  pwm;
  logic                  wrap;
  phase_mode_e           mode [NUM_PHASES];
  logic [NUM_PHASES-1:0] off_vec;

  cpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_en),
    .period_i (period_cfg),
    .duty_i   (duty_cfg),
    .pwm_o    (pwm),
    .wrap_o   (wrap)
  );

  cpwm_step_decode u_decode (
    .run    (run_en),
    .step_i (comm_step),
    .mode_o (mode)
  );

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    logic hi_req;
    logic lo_req;

    always_comb begin
      hi_req     = (mode[p] == PM_HIGH_PWM) && pwm;
      lo_req     = (mode[p] == PM_LOW_ON);
      off_vec[p] = (mode[p] == PM_OFF);
    end

    cpwm_dead_band #(.DT_W(DT_W)) u_dead (
      .clk      (clk),
      .rst_n    (rst_n),
      .dead_i   (dead_cfg),
      .hi_req_i (hi_req),
      .lo_req_i (lo_req),
      .hi_o     (gate_hi[p]),
      .lo_o     (gate_lo[p])
    );
  end

  AST_ONE_PHASE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && comm_step < 3'(NUM_STEPS)) |-> ($countones(off_vec) == 1)); // R6

  AST_IDLE_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en || comm_step >= 3'(NUM_STEPS)) |=> (gate_hi == '0 && gate_lo == '0)); // R7

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0); // R8

  AST_WRAP_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && wrap) |=> (u_carrier.cnt_q == '0)); // R2
endmodule

// File: tb/test_commutated_pwm6.sv
module test_commutated_pwm6;
  localparam int CW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run_en;
  logic [CW-1:0] period_cfg;
  logic [CW-1:0] duty_cfg;
  logic [DW-1:0] dead_cfg;
  logic [2:0]    comm_step;
  logic [2:0]    gate_hi;
  logic [2:0]    gate_lo;

  always #10 clk = ~clk;

  commutated_pwm6 #(.CNT_W(CW), .DT_W(DW)) i_commutated_pwm6 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .period_cfg(period_cfg),
    .duty_cfg(duty_cfg), .dead_cfg(dead_cfg), .comm_step(comm_step),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  typedef struct {
    string      req;
    logic [2:0] hi;
    logic [2:0] lo;
  } exp_t;

  exp_t  sb_q[$];
  int    n_checks = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    sb_on = 1'b0;
  bit    done = 1'b0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model of the requirements; pushes one expected item per clock
  int m_cnt, m_per, m_duty;
  bit m_h[3], m_l[3], m_last[3];
  int m_gap[3];

  always @(posedge clk) begin
    bit   pwm, valid;
    int   hp, lp, st;
    bit   nh[3], nl[3], nlast[3];
    int   ng[3];
    exp_t e;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_duty = 0;
      for (int p = 0; p < 3; p++) begin
        m_h[p] = 0; m_l[p] = 0; m_last[p] = 0; m_gap[p] = 255;
      end
    end else begin
      st    = int'(comm_step);
      pwm   = m_cnt < m_duty;
      valid = run_en && st < 6;
      hp    = st / 2;
      lp    = ((st + 1) / 2 + 1) % 3;
      for (int p = 0; p < 3; p++) begin
        bit hr, lr, ok;
        hr = valid && p == hp && pwm;
        lr = valid && p == lp;
        ok = m_gap[p] >= int'(dead_cfg);
        nh[p] = hr && !m_l[p] && (m_last[p] || ok);
        nl[p] = lr && !m_h[p] && (!m_last[p] || ok);
        ng[p] = (m_h[p] || m_l[p]) ? 0 : ((m_gap[p] == 255) ? 255 : m_gap[p] + 1);
        nlast[p] = m_h[p] ? 1'b1 : (m_l[p] ? 1'b0 : m_last[p]);
      end
      if (!run_en || m_cnt + 1 >= m_per) begin
        m_cnt = 0; m_per = int'(period_cfg); m_duty = int'(duty_cfg);
      end else begin
        m_cnt++;
      end
      for (int p = 0; p < 3; p++) begin
        m_h[p] = nh[p]; m_l[p] = nl[p]; m_gap[p] = ng[p]; m_last[p] = nlast[p];
        e.hi[p] = nh[p]; e.lo[p] = nl[p];
      end
      e.req = cur_req;
      if (sb_on) sb_q.push_back(e);
    end
  end

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check_eq(e.req, "gate_hi", int'(gate_hi), int'(e.hi));
      check_eq(e.req, "gate_lo", int'(gate_lo), int'(e.lo));
      // R8 overlap check on the outputs
      check_eq("R8", "hi&lo overlap", int'(gate_hi & gate_lo), 0);
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_gate(input int n, input int ph, input bit hi_side, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (hi_side ? gate_hi[ph] : gate_lo[ph]) c++;
    end
  endtask

  initial begin
    int c;
    int lo_tab[6];
    lo_tab = '{1, 2, 2, 0, 0, 1};
    rst_n = 1'b0; run_en = 1'b0; period_cfg = '0; duty_cfg = '0;
    dead_cfg = '0; comm_step = 3'd0;
    wait_clks(3);
    // R1 reset state
    check_eq("R1", "gate_hi in reset", int'(gate_hi), 0);
    check_eq("R1", "gate_lo in reset", int'(gate_lo), 0);
    rst_n = 1'b1;
    sb_on = 1'b1;

    // R2 basic period and duty; R5/R6 for step 0
    cur_req = "R2";
    period_cfg = 16'd10; duty_cfg = 16'd3; dead_cfg = 8'd2; comm_step = 3'd0; run_en = 1'b1;
    wait_clks(25);
    count_gate(50, 0, 1'b1, c); check_eq("R2", "hi0 on-clocks in 5 periods", c, 15);
    count_gate(50, 1, 1'b0, c); check_eq("R5", "lo1 on-clocks step0", c, 50);
    count_gate(20, 2, 1'b1, c); check_eq("R6", "hi2 floating", c, 0);
    count_gate(20, 2, 1'b0, c); check_eq("R6", "lo2 floating", c, 0);

    // R3 duty at or above period, and zero
    cur_req = "R3";
    duty_cfg = 16'd10; wait_clks(25);
    count_gate(50, 0, 1'b1, c); check_eq("R3", "hi0 duty==period", c, 50);
    duty_cfg = 16'd40000; wait_clks(25);
    count_gate(50, 0, 1'b1, c); check_eq("R3", "hi0 duty>period", c, 50);
    duty_cfg = 16'd0; wait_clks(25);
    count_gate(50, 0, 1'b1, c); check_eq("R3", "hi0 duty zero", c, 0);

    // R4 mid-cycle writes load only at wrap (model checks every clock)
    cur_req = "R4";
    duty_cfg = 16'd5; wait_clks(23);
    period_cfg = 16'd20; duty_cfg = 16'd10; wait_clks(3);
    duty_cfg = 16'd1; wait_clks(1);
    duty_cfg = 16'd10; wait_clks(45);
    count_gate(60, 0, 1'b1, c); check_eq("R4", "hi0 after new period", c, 30);
    period_cfg = 16'd0; duty_cfg = 16'd1; wait_clks(30);
    count_gate(10, 0, 1'b1, c); check_eq("R2", "hi0 period zero acts as one", c, 10);

    // R5 all six steps
    cur_req = "R5";
    period_cfg = 16'd8; duty_cfg = 16'd8;
    for (int s = 0; s < 6; s++) begin
      comm_step = 3'(s);
      wait_clks(12);
      count_gate(16, s / 2, 1'b1, c); check_eq("R5", $sformatf("hi side step %0d", s), c, 16);
      count_gate(16, lo_tab[s], 1'b0, c); check_eq("R5", $sformatf("lo side step %0d", s), c, 16);
    end

    // R7 invalid steps and disable
    cur_req = "R7";
    comm_step = 3'd6; wait_clks(2);
    count_gate(10, 0, 1'b1, c); check_eq("R7", "step6 hi0", c, 0);
    check_eq("R7", "step6 all gates", int'({gate_hi, gate_lo}), 0);
    comm_step = 3'd7; wait_clks(2);
    check_eq("R7", "step7 all gates", int'({gate_hi, gate_lo}), 0);
    comm_step = 3'd0; run_en = 1'b0; wait_clks(2);
    check_eq("R7", "disabled all gates", int'({gate_hi, gate_lo}), 0);
    period_cfg = 16'd6; duty_cfg = 16'd2; wait_clks(3);
    run_en = 1'b1;
    cur_req = "R9";
    wait_clks(30);
    count_gate(36, 0, 1'b1, c); check_eq("R9", "hi0 after restart", c, 12);

    // R8 dead time on a direct hand-over
    cur_req = "R8";
    period_cfg = 16'd8; duty_cfg = 16'd8; dead_cfg = 8'd6; comm_step = 3'd0;
    wait_clks(20);
    comm_step = 3'd3;
    c = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (gate_lo[0]) break;
      if (!gate_hi[0]) c++;
    end
    check_eq("R8", "both-off clocks, dead=6", c, 7);
    wait_clks(10);
    dead_cfg = 8'd0; wait_clks(5);
    comm_step = 3'd0;
    c = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (gate_hi[0]) break;
      if (!gate_lo[0]) c++;
    end
    check_eq("R8", "both-off clocks, dead=0", c, 1);
    duty_cfg = 16'd3; dead_cfg = 8'd0; wait_clks(40);

    sb_on = 1'b0;
    wait_clks(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule